// File: doc/BRIEF.md
# Prescaled Event Counter

This block is a timer with three software-visible 32-bit registers: a reload value, a down-counter, and an up-counter. The block does not generate its own time base. A one-cycle clock-enable strobe, `tick_en`, comes from outside. On each strobe the down-counter steps toward zero. Once it has reached zero, the next strobe loads it again from the reload register. That same strobe adds one to the up-counter, so the up-counter counts whole prescale periods.

Software reaches the registers through a single-cycle synchronous bus. A write takes effect at the clock edge. A read returns the addressed register without any wait state. Software can preset any of the three registers at any time. The down-counter can be loaded with a value larger than the reload value, and it then counts down from that value normally. A reload value of zero turns the up-counter into a plain tick counter.

Top module: `presc_evt_counter`

## Requirements
- R1: After reset, the down-counter and the up-counter both read zero, and the reload register reads `RST_PRESCALE` (default zero).
- R2: While the down-counter is non-zero, each tick lowers it by one. In a cycle without a tick and without a write, all three registers hold their values.
- R3: A tick that arrives while the down-counter is zero loads it with the reload value; it never wraps to all-ones. With reload 5 and a start value of 7, successive ticks give 6,5,4,3,2,1,0,5,4,3,2,1,0,5.
- R4: The up-counter rises by one on exactly the ticks that reload the down-counter, and on no other cycle unless it is written.
- R5: With a reload value of zero, the down-counter stays at zero once it gets there, and the up-counter rises on every tick.
- R6: A bus write with `wr_en` high stores `wdata` at byte offset 0x0 (reload), 0x4 (down-counter) or 0x8 (up-counter). A down-counter value above the reload value is accepted and counts down from there.
- R7: Writing the reload register leaves the current down-counter value unchanged. The new value is used at the next reload.
- R8: When a write and a tick fall in the same cycle, the written register takes the written value and ignores the tick. The other registers still act on the tick, and a reload in that cycle uses the reload value as it was before the write.
- R9: The up-counter wraps from 0xFFFFFFFF to 0 with no other effect.
- R10: `rdata` shows the register selected by `addr` in the same cycle (offsets 0x0, 0x4, 0x8). Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescale clock-enable strobe |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | ADDR_W (4) | Byte offset of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr` |

## Verification
The hardest case to reach is a write and a tick in the same cycle while the down-counter sits at zero. That one edge has to apply the write, perform the reload and bump the up-counter together. The stimulus first writes the down-counter to zero and the reload register to a known value. It then issues a tick in the same cycle as a write to each register in turn. The readback shows which register took the write and which took the tick. The up-counter wrap is reached by presetting it to 0xFFFFFFFF just before a reload tick, instead of counting up to it.

// File: rtl/pec_pkg.sv
package pec_pkg;
   localparam int unsigned OFS_PRESCALE = 'h0;
   localparam int unsigned OFS_DOWN     = 'h4;
   localparam int unsigned OFS_UP       = 'h8;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PRE  = 2'd1,
      SEL_DOWN = 2'd2,
      SEL_UP   = 2'd3
   } pec_sel_e;
endpackage

// File: rtl/pec_down_ctr.sv
module pec_down_ctr #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         we,
   input  logic [W-1:0] wval,
   input  logic [W-1:0] reload_val,
   output logic [W-1:0] cnt,
   output logic         reload_evt
);
   logic at_zero;

   assign at_zero    = (cnt == '0);
   assign reload_evt = tick && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (we)         cnt <= wval;
      else if (reload_evt) cnt <= reload_val;
      else if (tick)       cnt <= cnt - W'(1);
   end

   p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !we && cnt != '0) |=> cnt == W'($past(cnt) - W'(1)));
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !we) |=> $stable(cnt));
   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !we && cnt == '0) |=> cnt == $past(reload_val));
   p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> cnt == $past(wval));
endmodule

// File: rtl/pec_up_ctr.sv
module pec_up_ctr #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bump,
   input  logic         we,
   input  logic [W-1:0] wval,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (we)   cnt <= wval;
      else if (bump) cnt <= cnt + W'(1);
   end

   p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && !we) |=> cnt == W'($past(cnt) + W'(1)));
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bump && !we) |=> $stable(cnt));
   p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && !we && cnt == '1) |=> cnt == '0);
endmodule

// File: rtl/pec_bus_dec.sv
module pec_bus_dec
   import pec_pkg::*;
#(
   parameter int unsigned W        = 32,
   parameter int unsigned AW       = 4,
   parameter bit          READ_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  pre_val,
   input  logic [W-1:0]  down_val,
   input  logic [W-1:0]  up_val,
   output logic          we_pre,
   output logic          we_down,
   output logic          we_up,
   output logic [W-1:0]  rdata
);
   pec_sel_e sel;
   logic [W-1:0] rd_mux;

   always_comb begin
      if (addr == AW'(OFS_PRESCALE))  sel = SEL_PRE;
      else if (addr == AW'(OFS_DOWN)) sel = SEL_DOWN;
      else if (addr == AW'(OFS_UP))   sel = SEL_UP;
      else                            sel = SEL_NONE;
   end

   assign we_pre  = wr_en && (sel == SEL_PRE);
   assign we_down = wr_en && (sel == SEL_DOWN);
   assign we_up   = wr_en && (sel == SEL_UP);

   always_comb begin
      unique case (sel)
         SEL_PRE:  rd_mux = pre_val;
         SEL_DOWN: rd_mux = down_val;
         SEL_UP:   rd_mux = up_val;
         default:  rd_mux = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_flop
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign rdata = rd_mux;
         p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (addr != AW'(OFS_PRESCALE) && addr != AW'(OFS_DOWN) && addr != AW'(OFS_UP))
            |-> rdata == '0);
         p_read_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (addr == AW'(OFS_DOWN)) |-> rdata == down_val);
      end
   endgenerate

   p_one_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({we_pre, we_down, we_up}));
endmodule

// File: rtl/presc_evt_counter.sv
module presc_evt_counter #(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 4,
   parameter logic [31:0] RST_PRESCALE = 32'd0,
   parameter bit          READ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned MIN_AW = 4;

   generate
      if (DATA_W < 2 || DATA_W > 32) begin : g_bad_dw
         $error("presc_evt_counter: DATA_W must lie in 2..32");
      end
      if (ADDR_W < MIN_AW) begin : g_bad_aw
         $error("presc_evt_counter: ADDR_W too small for the register map");
      end
   endgenerate

   logic [DATA_W-1:0] pre_q, down_q, up_q;
   logic              we_pre, we_down, we_up;
   logic              reload_evt;

   pec_bus_dec #(.W(DATA_W), .AW(ADDR_W), .READ_REG(READ_REG)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .pre_val(pre_q), .down_val(down_q), .up_val(up_q),
      .we_pre(we_pre), .we_down(we_down), .we_up(we_up), .rdata(rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      pre_q <= DATA_W'(RST_PRESCALE);
      else if (we_pre) pre_q <= wdata;
   end

   pec_down_ctr #(.W(DATA_W)) u_down (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .we(we_down), .wval(wdata),
      .reload_val(pre_q), .cnt(down_q), .reload_evt(reload_evt)
   );

   pec_up_ctr #(.W(DATA_W)) u_up (
      .clk(clk), .rst_n(rst_n), .bump(reload_evt), .we(we_up), .wval(wdata),
      .cnt(up_q)
   );

   p_pre_write_no_touch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we_pre && !tick_en) |=> $stable(down_q));
   p_zero_reload_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !wr_en && pre_q == '0 && down_q == '0) |=> (down_q == '0 && up_q != $past(up_q)));
   p_reset_zero_r1: assert property (@(posedge clk)
      $past(!rst_n) |-> (down_q == '0 && up_q == '0));
endmodule

// File: tb/presc_evt_counter_tb_top.sv
module presc_evt_counter_tb_top;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;

   always #5 clk = ~clk;

   presc_evt_counter #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   logic [DW-1:0] m_pre = '0, m_down = '0, m_up = '0;

   logic [DW-1:0] q_exp[$];
   string         q_tag[$];
   event          sample_ev;

   // monitor: pops the expected item and compares it with the bus read
   initial begin
      forever begin
         @(sample_ev);
         #1;
         begin
            logic [DW-1:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (rdata !== e) begin
               fails++;
               $display("FAIL %s: got %h expected %h", t, rdata, e);
            end
         end
      end
   end

   function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
      case (a)
         4'h0:    return m_pre;
         4'h4:    return m_down;
         4'h8:    return m_up;
         default: return '0;
      endcase
   endfunction

   // one clock with the given stimulus; the model follows the requirements
   task automatic cyc(input bit t, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [DW-1:0] o_pre, o_down;
      @(negedge clk);
      tick_en = t; wr_en = w; addr = a; wdata = d;
      @(posedge clk);
      o_pre = m_pre; o_down = m_down;
      if (w && a == 4'h0) m_pre = d;
      if (w && a == 4'h4) m_down = d;
      else if (t) m_down = (o_down != '0) ? o_down - 1 : o_pre;
      if (w && a == 4'h8) m_up = d;
      else if (t && o_down == '0) m_up = m_up + 1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      cyc(1'b0, 1'b1, a, d);
   endtask

   // driver: pushes the expected value and hands the read to the monitor
   task automatic rd_exp(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
      @(negedge clk);
      tick_en = 1'b0; wr_en = 1'b0; addr = a;
      q_exp.push_back(e);
      q_tag.push_back(tag);
      ->sample_ev;
      #2;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      rd_exp(a, model_read(a), tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset values
      rd_exp(4'h0, 32'd0, "R1 prescale reset");
      rd_exp(4'h4, 32'd0, "R1 down reset");
      rd_exp(4'h8, 32'd0, "R1 up reset");
      // R10 unmapped offsets
      wr(4'h8, 32'h1234);
      rd_exp(4'hC, 32'd0, "R10 offset 0xC reads zero");
      rd_exp(4'h2, 32'd0, "R10 offset 0x2 reads zero");
      rd_exp(4'h8, 32'h1234, "R10 up readback");

      // R6 write down above reload, R3 sequence, R4 bumps
      wr(4'h8, 32'd0);
      wr(4'h0, 32'd5);
      wr(4'h4, 32'd7);
      rd_exp(4'h4, 32'd7, "R6 down written above reload");
      cyc(1'b0, 1'b0, 4'h0, 0);
      rd_exp(4'h4, 32'd7, "R2 hold without tick");
      begin
         logic [DW-1:0] seq [14] = '{6,5,4,3,2,1,0,5,4,3,2,1,0,5};
         logic [DW-1:0] ups [14] = '{0,0,0,0,0,0,0,1,1,1,1,1,1,2};
         for (int i = 0; i < 14; i++) begin
            cyc(1'b1, 1'b0, 4'h0, 0);
            rd_exp(4'h4, seq[i], $sformatf("R3 down step %0d", i));
            rd_exp(4'h8, ups[i], $sformatf("R4 up step %0d", i));
         end
      end

      // R7 reload write does not touch down, used at next reload
      cyc(1'b1, 1'b0, 4'h0, 0);
      cyc(1'b1, 1'b0, 4'h0, 0);
      wr(4'h0, 32'd2);
      rd_exp(4'h4, 32'd3, "R7 down unchanged by reload write");
      repeat (4) cyc(1'b1, 1'b0, 4'h0, 0);
      rd_exp(4'h4, 32'd2, "R7 new reload value applied");
      rd(4'h8, "R4 up after reload");

      // R5 zero reload sticks
      wr(4'h0, 32'd0);
      wr(4'h4, 32'd2);
      wr(4'h8, 32'd50);
      repeat (2) cyc(1'b1, 1'b0, 4'h0, 0);
      rd_exp(4'h8, 32'd50, "R5 no bump before zero");
      for (int i = 0; i < 4; i++) begin
         cyc(1'b1, 1'b0, 4'h0, 0);
         rd_exp(4'h4, 32'd0, "R5 down sticks at zero");
         rd_exp(4'h8, 32'd51 + i, "R5 up every tick");
      end

      // R8 write and tick together
      wr(4'h0, 32'd4);
      wr(4'h4, 32'd0);
      wr(4'h8, 32'd10);
      cyc(1'b1, 1'b1, 4'h4, 32'd9);
      rd_exp(4'h4, 32'd9, "R8 down write wins over tick");
      rd_exp(4'h8, 32'd11, "R8 up still bumps on reload tick");
      cyc(1'b1, 1'b1, 4'h8, 32'd100);
      rd_exp(4'h8, 32'd100, "R8 up write wins over tick");
      rd_exp(4'h4, 32'd8, "R8 down still decrements");
      wr(4'h4, 32'd0);
      cyc(1'b1, 1'b1, 4'h0, 32'd7);
      rd_exp(4'h4, 32'd4, "R8 reload uses old prescale");
      rd_exp(4'h0, 32'd7, "R8 prescale written");

      // R9 wrap
      wr(4'h8, 32'hFFFF_FFFF);
      wr(4'h4, 32'd0);
      cyc(1'b1, 1'b0, 4'h0, 0);
      rd_exp(4'h8, 32'd0, "R9 up wraps to zero");
      rd_exp(4'h4, 32'd7, "R9 reload alongside wrap");

      // mixed pattern against the model
      for (int i = 0; i < 40; i++) begin
         cyc(((i % 3) != 0), (i % 7) == 5, 4'h4, 32'(i % 4));
         rd(4'h4, "R2 mixed down");
         rd(4'h8, "R4 mixed up");
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule